// File: doc/BRIEF.md
# Bitmask Slot-Wheel Hub Arbiter

This block decides, cycle by cycle, which of eight cores may use a shared memory. Time is cut into a wheel of 32 positions that turns one position per clock. Each core holds a 32-bit ownership mask, and bit k of that mask means the core owns wheel position k. Every cycle the block puts out a one-hot grant naming the owner of the current position, or no grant at all when nobody owns it.

Ownership can change while the block runs. Each core may present a claim mask, asking for positions, and a release mask, giving positions back. A claim only wins positions that nobody owns. When two cores ask for the same free position in the same cycle, the lower-numbered core gets it. The block reports to each requester the positions it actually won, and it keeps a global occupancy vector that shows every owned position. A build parameter picks the reset layout. Equal-share mode spreads four positions per core so that the wheel behaves as a plain 1-in-8 rotation. Guaranteed-minimum mode gives each core one locked home position, which can never be released, and leaves the other 24 positions free.

Requests are control signals, not a data stream. A request is accepted on every cycle that its valid bit is high, so there is no back-pressure and no ready signal. The result comes back one cycle later on `claim_got` with `got_valid`.

Top module: `slot_wheel_arbiter`

## Requirements
- R1: `wheel_pos` is 0 in the first cycle after reset is released. It then advances by one on every clock and wraps from 31 to 0.
- R2: In equal-share mode (MODE = SHARE_EQUAL), reset gives core n the positions n, n+8, n+16 and n+24, so `occupancy` reads 0xFFFFFFFF.
- R3: In guaranteed-minimum mode (MODE = SHARE_MIN), reset gives core n only position 4n, so `occupancy` reads 0x11111111.
- R4: `grant` bit n is high exactly when core n owns position `wheel_pos`. All bits are low when that position is unowned, so `grant` is always zero-or-one-hot.
- R5: A claim wins only those positions in its mask that were unowned before the edge. One cycle after the request, `got_valid` bit n is high and `claim_got` bits [32n+31:32n] hold exactly the positions won.
- R6: When several cores claim the same free position in one cycle, the lowest-numbered core wins it, and no position is ever owned by two cores.
- R7: A release frees the requester's own positions, which other cores can then claim. Release bits for positions the core does not own have no effect.
- R8: In guaranteed-minimum mode, releasing a core's home position 4n has no effect, and that position stays owned by core n.
- R9: Claims and releases change ownership at the edge after they are presented. `occupancy` and `grant` reflect the change in the cycle right after that edge. Without a valid request, `occupancy` stays unchanged.
- R10: In guaranteed-minimum mode, one core can hold 25 positions: its home position plus all 24 free ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Bit n: core n presents a claim/release this cycle |
| claim_mask | input | 256 | Core n's requested positions at bits [32n+31:32n] |
| release_mask | input | 256 | Core n's positions to give back at bits [32n+31:32n] |
| claim_got | output | 256 | Core n's positions won by the previous request |
| got_valid | output | 8 | Bit n: `claim_got` field n answers a request |
| occupancy | output | 32 | Bit k set when any core owns position k |
| grant | output | 8 | One-hot owner of the current wheel position |
| wheel_pos | output | 5 | Current wheel position |

## Verification
The bench first applies directed patterns. One core claims every position, which shows the free-only rule and the 25-position ceiling apart from the equal-share case where nothing is free. A release that mixes owned, locked and foreign bits separates real frees from ignored ones. Two cores then race for one freed position, which exposes the priority order. After that, a long run of random sparse claim and release masks on several cores at once is compared every clock against a behavioural owner table. This run exercises the interplay of simultaneous releases, same-cycle contention and grant tracking as the wheel turns, in both reset modes side by side.

// File: rtl/swa_pkg.sv
package swa_pkg;
  typedef enum logic {
    SHARE_EQUAL = 1'b0,
    SHARE_MIN   = 1'b1
  } share_mode_e;
endpackage

// File: rtl/swa_wheel.sv
module swa_wheel #(
  parameter int NUM_POS = 32,
  localparam int PW = $clog2(NUM_POS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] pos
);
  localparam logic [PW-1:0] LAST = PW'(NUM_POS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)            pos <= '0;
    else if (pos == LAST)  pos <= '0;
    else                   pos <= pos + 1'b1;
  end

  assert_wheel_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pos == (($past(pos) == LAST) ? '0 : $past(pos) + 1'b1)));
endmodule

// File: rtl/swa_claim_resolve.sv
module swa_claim_resolve #(
  parameter int NUM_CORES = 8,
  parameter int NUM_POS   = 32
) (
  input  logic [NUM_CORES-1:0]         valid,
  input  logic [NUM_CORES*NUM_POS-1:0] claim,
  input  logic [NUM_POS-1:0]           occ,
  output logic [NUM_CORES*NUM_POS-1:0] won
);
  // Priority chain: each core sees what lower cores took this cycle.
  logic [NUM_POS-1:0] taken [NUM_CORES+1];
  assign taken[0] = occ;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic [NUM_POS-1:0] want;
    assign want = valid[i] ? claim[i*NUM_POS +: NUM_POS] : '0;
    assign won[i*NUM_POS +: NUM_POS] = want & ~taken[i];
    assign taken[i+1] = taken[i] | want;
  end
endmodule

// File: rtl/swa_owner_bank.sv
module swa_owner_bank
  import swa_pkg::*;
#(
  parameter int          NUM_CORES = 8,
  parameter int          NUM_POS   = 32,
  parameter share_mode_e MODE      = SHARE_EQUAL,
  localparam int         STRIDE    = NUM_POS / NUM_CORES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CORES-1:0]         valid,
  input  logic [NUM_CORES*NUM_POS-1:0] release_in,
  input  logic [NUM_CORES*NUM_POS-1:0] won,
  output logic [NUM_CORES*NUM_POS-1:0] owned,
  output logic [NUM_POS-1:0]           occ
);
  function automatic logic [NUM_POS-1:0] home_mask(int core);
    logic [NUM_POS-1:0] m;
    for (int k = 0; k < NUM_POS; k++) begin
      if (MODE == SHARE_EQUAL) m[k] = ((k % NUM_CORES) == core);
      else                     m[k] = (k == core * STRIDE);
    end
    return m;
  endfunction

  function automatic logic [NUM_POS-1:0] lock_mask(int core);
    return (MODE == SHARE_MIN) ? home_mask(core) : '0;
  endfunction

  logic [NUM_POS-1:0] own_q [NUM_CORES];

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_row
    localparam logic [NUM_POS-1:0] HOME = home_mask(i);
    localparam logic [NUM_POS-1:0] LOCK = lock_mask(i);
    logic [NUM_POS-1:0] rel_i, won_i, free_i;

    assign rel_i  = release_in[i*NUM_POS +: NUM_POS];
    assign won_i  = won[i*NUM_POS +: NUM_POS];
    assign free_i = valid[i] ? (rel_i & ~LOCK) : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) own_q[i] <= HOME;
      else        own_q[i] <= (own_q[i] & ~free_i) | won_i;
    end

    assign owned[i*NUM_POS +: NUM_POS] = own_q[i];

    assert_release_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid[i] |=> (own_q[i] & $past(rel_i & own_q[i] & ~LOCK)) == '0);

    assert_lock_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q[i] & LOCK) == LOCK);
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < NUM_CORES; i++) occ = occ | own_q[i];
  end

  for (genvar k = 0; k < NUM_POS; k++) begin : g_col
    logic [NUM_CORES-1:0] col;
    always_comb
      for (int i = 0; i < NUM_CORES; i++) col[i] = own_q[i][k];

    assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col) <= 1);
  end
endmodule

// File: rtl/slot_wheel_arbiter.sv
module slot_wheel_arbiter
  import swa_pkg::*;
#(
  parameter int          NUM_CORES = 8,
  parameter int          NUM_POS   = 32,
  parameter share_mode_e MODE      = SHARE_EQUAL,
  localparam int         PW        = $clog2(NUM_POS),
  localparam int         FW        = NUM_CORES * NUM_POS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] req_valid,
  input  logic [FW-1:0]        claim_mask,
  input  logic [FW-1:0]        release_mask,
  output logic [FW-1:0]        claim_got,
  output logic [NUM_CORES-1:0] got_valid,
  output logic [NUM_POS-1:0]   occupancy,
  output logic [NUM_CORES-1:0] grant,
  output logic [PW-1:0]        wheel_pos
);
  logic [FW-1:0] won, owned;

  swa_wheel #(.NUM_POS(NUM_POS)) u_wheel (
    .clk(clk), .rst_n(rst_n), .pos(wheel_pos)
  );

  swa_claim_resolve #(.NUM_CORES(NUM_CORES), .NUM_POS(NUM_POS)) u_resolve (
    .valid(req_valid), .claim(claim_mask), .occ(occupancy), .won(won)
  );

  swa_owner_bank #(.NUM_CORES(NUM_CORES), .NUM_POS(NUM_POS), .MODE(MODE)) u_bank (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .release_in(release_mask),
    .won(won), .owned(owned), .occ(occupancy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim_got <= '0;
      got_valid <= '0;
    end else begin
      claim_got <= won;
      got_valid <= req_valid;
    end
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_grant
    logic [NUM_POS-1:0] row;
    assign row = owned[i*NUM_POS +: NUM_POS];
    assign grant[i] = row[wheel_pos];

    assert_got_free_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[i] |=> (claim_got[i*NUM_POS +: NUM_POS] &
        $past(occupancy | ~claim_mask[i*NUM_POS +: NUM_POS])) == '0);
  end

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) == occupancy[wheel_pos]);

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |=> $stable(occupancy));
endmodule

// File: tb/slot_wheel_arbiter_tb.sv
module slot_wheel_arbiter_tb_top;
  import swa_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]   valid_r = '0;
  logic [255:0] claim_r = '0;
  logic [255:0] rel_r   = '0;

  logic [255:0] got_w  [2];
  logic [7:0]   gv_w   [2];
  logic [31:0]  occ_w  [2];
  logic [7:0]   gnt_w  [2];
  logic [4:0]   pos_w  [2];

  slot_wheel_arbiter #(.MODE(SHARE_EQUAL)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(valid_r), .claim_mask(claim_r),
    .release_mask(rel_r), .claim_got(got_w[0]), .got_valid(gv_w[0]),
    .occupancy(occ_w[0]), .grant(gnt_w[0]), .wheel_pos(pos_w[0])
  );

  slot_wheel_arbiter #(.MODE(SHARE_MIN)) dut_min_i (
    .clk(clk), .rst_n(rst_n), .req_valid(valid_r), .claim_mask(claim_r),
    .release_mask(rel_r), .claim_got(got_w[1]), .got_valid(gv_w[1]),
    .occupancy(occ_w[1]), .grant(gnt_w[1]), .wheel_pos(pos_w[1])
  );

  // Behavioural reference: owner per position, -1 means free.
  int          m_own [2][32];
  logic [31:0] m_got [2][8];
  logic [7:0]  m_gv;
  int          m_pos;
  int          n_tests = 0;
  int          n_fail  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int md = 0; md < 2; md++) begin
      for (int k = 0; k < 32; k++)
        m_own[md][k] = (md == 0) ? (k % 8) : ((k % 4 == 0) ? k / 4 : -1);
      for (int i = 0; i < 8; i++) m_got[md][i] = '0;
    end
    m_gv  = '0;
    m_pos = 0;
  endtask

  task automatic model_edge();
    for (int md = 0; md < 2; md++) begin
      logic [31:0] taken = '0;
      for (int i = 0; i < 8; i++) begin
        m_got[md][i] = '0;
        if (valid_r[i])
          for (int k = 0; k < 32; k++)
            if (claim_r[i*32+k] && m_own[md][k] < 0 && !taken[k]) begin
              m_got[md][i][k] = 1'b1;
              taken[k] = 1'b1;
            end
      end
      for (int i = 0; i < 8; i++)
        if (valid_r[i])
          for (int k = 0; k < 32; k++)
            if (rel_r[i*32+k] && m_own[md][k] == i && !(md == 1 && k == 4*i))
              m_own[md][k] = -1;
      for (int i = 0; i < 8; i++)
        for (int k = 0; k < 32; k++)
          if (m_got[md][i][k]) m_own[md][k] = i;
    end
    m_gv  = valid_r;
    m_pos = (m_pos + 1) % 32;
  endtask

  function automatic logic [31:0] exp_occ(int md);
    logic [31:0] o;
    for (int k = 0; k < 32; k++) o[k] = (m_own[md][k] >= 0);
    return o;
  endfunction

  task automatic compare_all();
    for (int md = 0; md < 2; md++) begin
      logic [7:0] eg = '0;
      if (m_own[md][m_pos] >= 0) eg[m_own[md][m_pos]] = 1'b1;
      check(pos_w[md] == 5'(m_pos), "R1", "wheel_pos", 32'(pos_w[md]), 32'(m_pos));
      check(occ_w[md] == exp_occ(md), "R9", "occupancy", occ_w[md], exp_occ(md));
      check(gnt_w[md] == eg, "R4", "grant", 32'(gnt_w[md]), 32'(eg));
      check(gv_w[md] == m_gv, "R5", "got_valid", 32'(gv_w[md]), 32'(m_gv));
      for (int i = 0; i < 8; i++)
        check(got_w[md][i*32 +: 32] == m_got[md][i], "R5", "claim_got",
              got_w[md][i*32 +: 32], m_got[md][i]);
    end
  endtask

  // Inputs change at negedge; the model follows the edge; outputs checked at negedge.
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    valid_r = '0;
    claim_r = '0;
    rel_r   = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare_all();
    check(occ_w[0] == 32'hFFFFFFFF, "R2", "equal-share reset occupancy", occ_w[0], 32'hFFFFFFFF);
    check(occ_w[1] == 32'h11111111, "R3", "min-mode reset occupancy", occ_w[1], 32'h11111111);
    check(gnt_w[0] == 8'h01 && gnt_w[1] == 8'h01, "R2", "grant at position 0",
          {gnt_w[0], gnt_w[1]}, 32'h0101);

    // R10: core 3 claims every position.
    valid_r[3] = 1'b1;
    claim_r[3*32 +: 32] = 32'hFFFFFFFF;
    step();
    check(got_w[1][96 +: 32] == 32'hEEEEEEEE, "R10", "min-mode core 3 won",
          got_w[1][96 +: 32], 32'hEEEEEEEE);
    check(occ_w[1] == 32'hFFFFFFFF, "R10", "min-mode full wheel", occ_w[1], 32'hFFFFFFFF);
    check(got_w[0][96 +: 32] == 32'h0, "R5", "equal-share claim of owned", got_w[0][96 +: 32], 32'h0);

    // R7/R8: core 3 releases position 1 and its home position 12.
    valid_r[3] = 1'b1;
    rel_r[3*32 +: 32] = 32'h00001002;
    step();
    check(occ_w[1] == 32'hFFFFFFFD, "R8", "locked position kept", occ_w[1], 32'hFFFFFFFD);
    check(occ_w[0] == 32'hFFFFFFFF, "R7", "release of unowned ignored", occ_w[0], 32'hFFFFFFFF);

    // R6: cores 1 and 5 race for position 1.
    valid_r[1] = 1'b1;
    valid_r[5] = 1'b1;
    claim_r[1*32 +: 32] = 32'h2;
    claim_r[5*32 +: 32] = 32'h2;
    step();
    check(got_w[1][32 +: 32] == 32'h2, "R6", "lower core wins", got_w[1][32 +: 32], 32'h2);
    check(got_w[1][160 +: 32] == 32'h0, "R6", "higher core loses", got_w[1][160 +: 32], 32'h0);

    // Random traffic, compared every clock against the model (R4 R5 R6 R7 R9).
    for (int c = 0; c < 3000; c++) begin
      valid_r = 8'($urandom);
      for (int i = 0; i < 8; i++) begin
        claim_r[i*32 +: 32] = $urandom & $urandom & $urandom;
        rel_r[i*32 +: 32]   = $urandom & $urandom;
      end
      step();
      if (c % 4 == 0) step();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule